// File: doc/BRIEF.md
# Programmable Priority Master Arbiter

This block decides which physical master port owns one crossbar slave port. Every master port carries a programmable priority value. Among the ports that request, the one with the numerically smallest value wins, so 0 is the most urgent level. Every code is a usable level: no value switches a port off. After reset, each port's priority equals its own physical port number.

Once granted, a master keeps the slave until its data phase completes. The arbiter then re-arbitrates on the next idle cycle. One physical port is shared between a core data bus and a debug trace master. A small front stage picks between these two before the main arbitration. The core normally wins, but the debug master takes the port once it has waited long enough.

With each grant, the block drives the logical master ID seen by the slave. For port p, the ID is p/2, so a core's instruction and data ports carry the same ID. The debug master is tagged by setting the ID's top bit. Priority writes are accepted at any time, but they only change arbitration at an arbitration point.

Top module: `xbar_prio_arbiter`

## Requirements
- R1: While and after reset, `gnt_o`, `gnt_dbg_o`, `gnt_valid_o` and `mid_o` are all zero. Port p starts with priority p, so with every port requesting, the first grant goes to port 0.
- R2: In an idle cycle with requests present, the grant goes to the requesting port with the smallest priority value. It appears one clock edge later as a one-hot bit p of `gnt_o`.
- R3: When requesting ports hold equal priority values, the port with the lower physical number is granted.
- R4: Every priority value, including the largest (15 for 4-bit priorities), is a valid level. A lone requester at that level is granted.
- R5: A grant, its ID and its debug flag stay unchanged until `xfer_done_i` is sampled high during the grant. The grant then drops on the next edge, and a new arbitration takes place in the following idle cycle.
- R6: `xfer_done_i` sampled while no grant is active has no effect: the outputs stay zero.
- R7: A write to `cfg_prio_i` for port `cfg_port_i` made while idle governs arbitration from the next cycle on. A write made during a grant leaves the current grant unchanged. It takes effect in the arbitration that follows the completion of that grant.
- R8: On the shared port (default port 1), `dbg_req_i` alone wins that port. When the core data request is also high, the core wins, unless the debug master has requested for at least DBG_WAIT cycles (default 6) without being granted. A granted debug master sets `gnt_dbg_o` together with the shared port's bit in `gnt_o`.
- R9: `mid_o` equals the granted port number divided by 2 in its low bits. The top bit of `mid_o` is 0 for a core and 1 for the debug master, so a debug grant on port 1 shows 4'b1000.
- R10: `gnt_o` has at most one bit set, and `gnt_valid_o` is high exactly when one bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N_PORTS | Request per physical master port (core side on the shared port) |
| dbg_req_i | input | 1 | Debug trace master request on the shared port |
| xfer_done_i | input | 1 | Data phase of the current owner completes this cycle |
| cfg_we_i | input | 1 | Priority write strobe |
| cfg_port_i | input | IDX_W | Port whose priority is written |
| cfg_prio_i | input | PRIO_W | Priority value written |
| gnt_o | output | N_PORTS | One-hot grant to the owning physical port |
| gnt_dbg_o | output | 1 | Grant on the shared port belongs to the debug master |
| gnt_valid_o | output | 1 | A grant is active |
| mid_o | output | ID_W | Logical master ID presented to the slave |

## Verification
A corrupted active priority table shows up at the very next arbitration as a grant to the wrong port. The bench's per-cycle reference model flags it one edge after that idle cycle. A lost or stuck busy state either drops a grant while the data phase is still running or blocks the next grant. Both differ from the model within a cycle of the completion pulse. A debug wait counter that is off by one moves the debug grant by one transfer on the shared port, and the model comparison catches that as well. The bound checker also catches a wrong ID top bit or a priority table that changes in the middle of a grant, on the edge where it happens.

// File: rtl/xpa_pkg.sv
package xpa_pkg;

    typedef enum logic {
        SRC_CORE = 1'b0,
        SRC_DBG  = 1'b1
    } src_e;

    typedef struct packed {
        logic busy;
        src_e src;
    } own_t;

    // Logical ID: port pairs share a core number; top bit tags the debug master.
    function automatic logic [7:0] make_id(input int unsigned port,
                                           input src_e src,
                                           input int unsigned id_w);
        logic [7:0] id;
        id = 8'((port >> 1) & ((32'd1 << (id_w - 1)) - 1));
        if (src == SRC_DBG) id[id_w-1] = 1'b1;
        return id;
    endfunction

endpackage

// File: rtl/xpa_prio_table.sv
module xpa_prio_table #(
    parameter int N_PORTS = 4,
    parameter int PRIO_W  = 4,
    parameter int IDX_W   = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [IDX_W-1:0]          wport,
    input  logic [PRIO_W-1:0]         wprio,
    input  logic                      commit,
    output logic [N_PORTS*PRIO_W-1:0] prio_flat
);

    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        logic [PRIO_W-1:0] shadow_q;
        logic [PRIO_W-1:0] active_q;
        logic [PRIO_W-1:0] shadow_nxt;

        assign shadow_nxt = (we && (wport == IDX_W'(p))) ? wprio : shadow_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                shadow_q <= PRIO_W'(p);
                active_q <= PRIO_W'(p);
            end else begin
                shadow_q <= shadow_nxt;
                if (commit) active_q <= shadow_nxt;
            end
        end

        assign prio_flat[p*PRIO_W +: PRIO_W] = active_q;
    end

endmodule

// File: rtl/xpa_pick.sv
module xpa_pick #(
    parameter int N_PORTS = 4,
    parameter int PRIO_W  = 4,
    parameter int IDX_W   = 2
) (
    input  logic [N_PORTS-1:0]        req,
    input  logic [N_PORTS*PRIO_W-1:0] prio_flat,
    output logic                      any,
    output logic [IDX_W-1:0]          win
);

    logic [PRIO_W-1:0] best;

    // Strict less-than keeps the lower port on a tie.
    always_comb begin
        any  = 1'b0;
        win  = '0;
        best = '0;
        for (int p = 0; p < N_PORTS; p++) begin
            if (req[p] && (!any || (prio_flat[p*PRIO_W +: PRIO_W] < best))) begin
                any  = 1'b1;
                win  = IDX_W'(p);
                best = prio_flat[p*PRIO_W +: PRIO_W];
            end
        end
    end

endmodule

// File: rtl/xpa_share.sv
module xpa_share #(
    parameter int DBG_WAIT = 6,
    parameter int CNT_W    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic core_req,
    input  logic dbg_req,
    input  logic dbg_taken,
    output logic eff_req,
    output logic sel_dbg
);

    logic [CNT_W-1:0] wait_q;

    assign eff_req = core_req | dbg_req;
    assign sel_dbg = dbg_req && (!core_req || (wait_q >= CNT_W'(DBG_WAIT)));

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_q <= '0;
        end else if (!dbg_req || dbg_taken) begin
            wait_q <= '0;
        end else if (wait_q < CNT_W'(DBG_WAIT)) begin
            wait_q <= wait_q + 1'b1;
        end
    end

endmodule

// File: rtl/xbar_prio_arbiter.sv
module xbar_prio_arbiter #(
    parameter int N_PORTS  = 4,
    parameter int PRIO_W   = 4,
    parameter int ID_W     = 4,
    parameter int SHARED   = 1,
    parameter int DBG_WAIT = 6,
    localparam int IDX_W   = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
    localparam int CNT_W   = $clog2(DBG_WAIT + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_PORTS-1:0] req_i,
    input  logic               dbg_req_i,
    input  logic               xfer_done_i,
    input  logic               cfg_we_i,
    input  logic [IDX_W-1:0]   cfg_port_i,
    input  logic [PRIO_W-1:0]  cfg_prio_i,
    output logic [N_PORTS-1:0] gnt_o,
    output logic               gnt_dbg_o,
    output logic               gnt_valid_o,
    output logic [ID_W-1:0]    mid_o
);
    import xpa_pkg::*;

    own_t                      own_q;
    logic [N_PORTS-1:0]        gnt_q;
    logic [ID_W-1:0]           mid_q;
    logic [N_PORTS*PRIO_W-1:0] prio_flat;
    logic [N_PORTS-1:0]        req_eff;
    logic                      shared_req;
    logic                      sel_dbg;
    logic                      any;
    logic [IDX_W-1:0]          win;
    logic                      dbg_taken;
    logic                      commit;
    src_e                      win_src;

    assign commit    = !own_q.busy || xfer_done_i;
    assign win_src   = ((win == IDX_W'(SHARED)) && sel_dbg) ? SRC_DBG : SRC_CORE;
    assign dbg_taken = !own_q.busy && any && (win_src == SRC_DBG);

    xpa_prio_table #(.N_PORTS(N_PORTS), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_table (
        .clk       (clk),
        .rst       (rst),
        .we        (cfg_we_i),
        .wport     (cfg_port_i),
        .wprio     (cfg_prio_i),
        .commit    (commit),
        .prio_flat (prio_flat)
    );

    xpa_share #(.DBG_WAIT(DBG_WAIT), .CNT_W(CNT_W)) u_share (
        .clk       (clk),
        .rst       (rst),
        .core_req  (req_i[SHARED]),
        .dbg_req   (dbg_req_i),
        .dbg_taken (dbg_taken),
        .eff_req   (shared_req),
        .sel_dbg   (sel_dbg)
    );

    for (genvar p = 0; p < N_PORTS; p++) begin : g_req
        if (p == SHARED) begin : g_sh
            assign req_eff[p] = shared_req;
        end else begin : g_pl
            assign req_eff[p] = req_i[p];
        end
    end

    xpa_pick #(.N_PORTS(N_PORTS), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_pick (
        .req       (req_eff),
        .prio_flat (prio_flat),
        .any       (any),
        .win       (win)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            own_q <= '{busy: 1'b0, src: SRC_CORE};
            gnt_q <= '0;
            mid_q <= '0;
        end else if (!own_q.busy && any) begin
            own_q <= '{busy: 1'b1, src: win_src};
            gnt_q <= N_PORTS'(1) << win;
            mid_q <= ID_W'(make_id(int'(win), win_src, ID_W));
        end else if (own_q.busy && xfer_done_i) begin
            own_q <= '{busy: 1'b0, src: SRC_CORE};
            gnt_q <= '0;
            mid_q <= '0;
        end
    end

    assign gnt_o       = gnt_q;
    assign gnt_dbg_o   = own_q.busy && (own_q.src == SRC_DBG);
    assign gnt_valid_o = own_q.busy;
    assign mid_o       = mid_q;

endmodule

// File: rtl/xpa_checker.sv
module xpa_checker #(
    parameter int N_PORTS = 4,
    parameter int PRIO_W  = 4,
    parameter int ID_W    = 4,
    parameter int SHARED  = 1
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      xfer_done_i,
    input logic [N_PORTS-1:0]        gnt_o,
    input logic                      gnt_dbg_o,
    input logic                      gnt_valid_o,
    input logic [ID_W-1:0]           mid_o,
    input logic [N_PORTS*PRIO_W-1:0] prio_flat
);

    assert_onehot_grant_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt_o) && (gnt_valid_o == (gnt_o != '0)));

    assert_grant_hold_R5: assert property (@(posedge clk) disable iff (rst)
        gnt_valid_o && !xfer_done_i |=>
            gnt_valid_o && $stable(gnt_o) && $stable(mid_o) && $stable(gnt_dbg_o));

    assert_release_R5: assert property (@(posedge clk) disable iff (rst)
        gnt_valid_o && xfer_done_i |=> !gnt_valid_o);

    assert_prio_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        gnt_valid_o && !xfer_done_i |=> $stable(prio_flat));

    assert_dbg_on_shared_R8: assert property (@(posedge clk) disable iff (rst)
        gnt_dbg_o |-> gnt_o[SHARED]);

    assert_id_tag_R9: assert property (@(posedge clk) disable iff (rst)
        gnt_valid_o |-> (mid_o[ID_W-1] == gnt_dbg_o));

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        !gnt_valid_o |-> (!gnt_dbg_o && (mid_o == '0)));

endmodule

bind xbar_prio_arbiter xpa_checker #(
    .N_PORTS (N_PORTS),
    .PRIO_W  (PRIO_W),
    .ID_W    (ID_W),
    .SHARED  (SHARED)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .xfer_done_i (xfer_done_i),
    .gnt_o       (gnt_o),
    .gnt_dbg_o   (gnt_dbg_o),
    .gnt_valid_o (gnt_valid_o),
    .mid_o       (mid_o),
    .prio_flat   (prio_flat)
);

// File: tb/xbar_prio_arbiter_bench.sv
`timescale 1ns/1ps
module xbar_prio_arbiter_bench;
    localparam int N    = 4;
    localparam int PW   = 4;
    localparam int IW   = 4;
    localparam int SH   = 1;
    localparam int WLIM = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  req = '0;
    logic          dbg_req = 1'b0;
    logic          xfer_done = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_port = '0;
    logic [PW-1:0] cfg_prio = '0;
    logic [N-1:0]  gnt;
    logic          gnt_dbg;
    logic          gnt_valid;
    logic [IW-1:0] mid;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    string tag = "R1";
    bit started = 1'b0;

    always #2 clk = ~clk;

    xbar_prio_arbiter #(.N_PORTS(N), .PRIO_W(PW), .ID_W(IW), .SHARED(SH), .DBG_WAIT(WLIM))
    u_xbar_prio_arbiter (
        .clk(clk), .rst(rst), .req_i(req), .dbg_req_i(dbg_req), .xfer_done_i(xfer_done),
        .cfg_we_i(cfg_we), .cfg_port_i(cfg_port), .cfg_prio_i(cfg_prio),
        .gnt_o(gnt), .gnt_dbg_o(gnt_dbg), .gnt_valid_o(gnt_valid), .mid_o(mid)
    );

    // ---------------- reference model ----------------
    int m_shadow[N];
    int m_active[N];
    bit m_busy;
    int m_own;
    bit m_dbg;
    int m_wait;

    always @(posedge clk) begin
        started <= 1'b1;
        cyc <= cyc + 1;
        if (rst) begin
            for (int p = 0; p < N; p++) begin m_shadow[p] = p; m_active[p] = p; end
            m_busy = 0; m_own = 0; m_dbg = 0; m_wait = 0;
        end else begin
            int  win;
            bit  pick_dbg;
            bit  commit;
            bit  took_dbg;
            win = -1;
            commit = !m_busy || xfer_done;
            for (int p = 0; p < N; p++) begin
                bit r;
                r = req[p] || (p == SH && dbg_req);
                if (r && (win < 0 || m_active[p] < m_active[win])) win = p;
            end
            pick_dbg = dbg_req && (!req[SH] || m_wait >= WLIM);
            took_dbg = !m_busy && win == SH && pick_dbg;
            if (!dbg_req || took_dbg) m_wait = 0;
            else if (m_wait < WLIM) m_wait++;
            if (!m_busy && win >= 0) begin
                m_busy = 1; m_own = win; m_dbg = took_dbg;
            end else if (m_busy && xfer_done) begin
                m_busy = 0; m_dbg = 0;
            end
            if (cfg_we) m_shadow[cfg_port] = cfg_prio;
            if (commit) for (int p = 0; p < N; p++) m_active[p] = m_shadow[p];
        end
    end

    always @(negedge clk) begin
        if (started) begin
            logic [N-1:0]  e_gnt;
            logic [IW-1:0] e_mid;
            e_gnt = m_busy ? (N'(1) << m_own) : '0;
            e_mid = m_busy ? IW'((m_own >> 1) | (m_dbg ? 8 : 0)) : '0;
            n_chk++;
            if (gnt !== e_gnt || gnt_valid !== m_busy || gnt_dbg !== (m_busy && m_dbg) || mid !== e_mid) begin
                n_fail++;
                $display("FAIL %s model cyc %0d: gnt/valid/dbg/mid actual %b/%b/%b/%h expected %b/%b/%b/%h",
                         tag, cyc, gnt, gnt_valid, gnt_dbg, mid, e_gnt, m_busy, m_busy && m_dbg, e_mid);
            end
            n_chk++;
            if ($countones(gnt) > 1 || gnt_valid !== (gnt != '0)) begin
                n_fail++;
                $display("FAIL R10 cyc %0d: gnt %b valid %b actual, expected one-hot matching valid", cyc, gnt, gnt_valid);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string t, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", t, act, exp);
        end
    endtask

    task automatic wcfg(input int port, input int prio);
        cfg_we = 1; cfg_port = 2'(port); cfg_prio = PW'(prio);
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic xfer(input int len, input bit drop, output int port, output int id, output bit isdbg);
        int guard;
        guard = 0;
        while (!gnt_valid && guard < 60) begin @(negedge clk); guard++; end
        port = -1;
        for (int p = 0; p < N; p++) if (gnt[p]) port = p;
        id = int'(mid); isdbg = gnt_dbg;
        repeat (len - 1) @(negedge clk);
        xfer_done = 1;
        @(negedge clk);
        xfer_done = 0;
        if (drop) begin
            if (isdbg) dbg_req = 0;
            else if (port >= 0) req[port] = 0;
        end
    endtask

    initial begin
        wait (cyc > 20000);
        n_fail++;
        $display("FAIL watchdog R5: run hung, actual cycle %0d expected completion", cyc);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        int pt, id;
        bit d;
        bit seen;
        logic [15:0] lfsr;

        repeat (3) @(negedge clk);
        // R1 reset state
        tag = "R1";
        chk("R1 gnt in reset", int'(gnt), 0);
        chk("R1 valid in reset", int'(gnt_valid), 0);
        rst = 0;
        @(negedge clk);
        chk("R1 gnt after reset", int'(gnt), 0);
        chk("R1 mid after reset", int'(mid), 0);

        // R1/R9 reset priorities give order 0,1,2,3
        req = 4'b1111;
        xfer(2, 1, pt, id, d); chk("R1 first grant port", pt, 0); chk("R9 id port0", id, 0);
        tag = "R9";
        xfer(1, 1, pt, id, d); chk("R1 second grant port", pt, 1); chk("R9 id port1", id, 0);
        xfer(3, 1, pt, id, d); chk("R1 third grant port", pt, 2); chk("R9 id port2", id, 1);
        xfer(1, 1, pt, id, d); chk("R1 fourth grant port", pt, 3); chk("R9 id port3", id, 1);

        // R6 done while idle
        tag = "R6";
        @(negedge clk);
        xfer_done = 1; repeat (2) @(negedge clk); xfer_done = 0;
        chk("R6 valid after idle done", int'(gnt_valid), 0);
        chk("R6 mid after idle done", int'(mid), 0);

        // R2 + R7 idle writes
        tag = "R2";
        wcfg(3, 0); wcfg(0, 3);
        req = 4'b1001;
        xfer(1, 1, pt, id, d); chk("R2 lowest value first", pt, 3);
        xfer(1, 1, pt, id, d); chk("R2 then port0", pt, 0);

        // R3 tie
        tag = "R3";
        wcfg(2, 1);
        req = 4'b0110;
        xfer(1, 1, pt, id, d); chk("R3 tie lower port", pt, 1);
        xfer(1, 1, pt, id, d); chk("R3 tie then port2", pt, 2);

        // R4 max value still granted; R7 write during grant
        tag = "R4";
        wcfg(0, 15);
        req = 4'b0001;
        @(negedge clk); @(negedge clk);
        chk("R4 prio 15 granted", int'(gnt), 1);
        tag = "R7";
        wcfg(1, 0); wcfg(3, 5);
        req = 4'b1011;
        repeat (2) @(negedge clk);
        chk("R7 grant held during write", int'(gnt), 1);
        chk("R5 valid held", int'(gnt_valid), 1);
        xfer_done = 1; @(negedge clk); xfer_done = 0; req[0] = 0;
        xfer(1, 1, pt, id, d); chk("R7 deferred write applied", pt, 1);
        xfer(1, 1, pt, id, d); chk("R7 port3 after", pt, 3);

        // R8 shared port
        tag = "R8";
        req = 4'b0010; dbg_req = 1;
        xfer(1, 0, pt, id, d); chk("R8 core first", int'(d), 0); chk("R8 core on shared", pt, 1);
        seen = 0;
        for (int k = 0; k < 12 && !seen; k++) begin
            xfer(1, 0, pt, id, d);
            if (d) seen = 1;
        end
        chk("R8 debug wins after waiting", int'(seen), 1);
        dbg_req = 0; req = '0;
        repeat (2) @(negedge clk);
        dbg_req = 1;
        xfer(2, 1, pt, id, d);
        chk("R8 debug alone", int'(d), 1); chk("R8 debug port", pt, 1); chk("R9 debug id", id, 8);

        // mixed traffic against the model
        tag = "R2";
        lfsr = 16'hACE1;
        for (int k = 0; k < 600; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            req = lfsr[3:0];
            dbg_req = lfsr[4] & lfsr[5];
            xfer_done = lfsr[6];
            cfg_we = lfsr[7] & lfsr[8];
            cfg_port = lfsr[11:10];
            cfg_prio = lfsr[15:12];
            @(negedge clk);
        end
        req = '0; dbg_req = 0; xfer_done = 1; cfg_we = 0;
        @(negedge clk);
        xfer_done = 0;
        repeat (3) @(negedge clk);
        chk("R5 idle at end", int'(gnt_valid), 0);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule